// File: doc/BRIEF.md
# Destination Address Receive Filter

This block judges each incoming Ethernet frame on its destination address alone. The six destination bytes arrive one per valid cycle on a byte stream, and the first of them carries a start-of-frame marker. While the bytes go by, the block assembles the 48-bit address and runs a CRC-32 over it. On the clock edge that takes the sixth byte, it registers a single accept or reject verdict.

Five paths can admit a frame:

- an unconditional promiscuous path;
- a broadcast path for the all-ones address;
- an exact station-address match for unicast frames;
- a multicast path that looks up one bit of a 64-bin hash table;
- an all-multicast override that makes every bin of that table count as set.

Every mode bit, both 32-bit table words and the two 24-bit halves of the station address are plain input ports. Upstream logic drives them steadily.

A receive path places this filter next to its frame buffer. When the verdict pulse says reject, the buffer drops the frame. The filter holds no frame data and does no FCS check.

Top module: `dafilt_top`

## Requirements
- R1: `decisionValid` is high for exactly one cycle. That cycle follows the clock edge that consumes the sixth destination byte, and `decisionValid` is never high at any other time.
- R2: A byte sampled with `byteValid` and `frameStart` both high is destination byte 0, and it abandons any address still in progress. Bytes without `frameStart` are ignored in two cases: when no address is being collected, and after the sixth byte of an address.
- R3: When `cfgPromisc` is 1, every verdict is accept.
- R4: A frame is unicast when bit 0 of byte 0 is 0. It is accepted when `cfgUcastEn` is 1 and all six bytes equal the station address. `staHi[23:16]` holds byte 0, `staHi[7:0]` holds byte 2, `staLo[23:16]` holds byte 3 and `staLo[7:0]` holds byte 5.
- R5: The hash index is bits 31:26 of a CRC-32 with polynomial 0x04C11DB7, worked out as follows:
  - the register is preset to all ones before byte 0;
  - the register shifts toward its MSB;
  - each byte enters least significant bit first;
  - there is no final inversion.
- R6: Index bit 5 selects `hashWord1` when 1 and `hashWord0` when 0, and index bits 4:0 select the bit within that word. A non-broadcast multicast frame is accepted only when `cfgMcastEn` and `cfgHashEn` are both 1 and the selected bit is 1.
- R7: `cfgAllMcast` makes every table bit count as 1. The multicast path still needs `cfgMcastEn` and `cfgHashEn`.
- R8: The all-ones address is accepted exactly when `cfgBcastEn` (or `cfgPromisc`) is 1. It never passes through the hash table.
- R9: Idle cycles between address bytes (`byteValid` low) delay the verdict but do not change it.
- R10: When no path admits the frame, the verdict is reject. `accept` is 0 in every cycle in which `decisionValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | `byteData` holds an address byte this cycle |
| frameStart | input | 1 | Marks the first destination byte of a frame |
| byteData | input | 8 | Destination address byte |
| cfgUcastEn | input | 1 | Enable exact station-address match |
| cfgMcastEn | input | 1 | Enable the multicast path |
| cfgHashEn | input | 1 | Enable the hash table lookup |
| cfgBcastEn | input | 1 | Accept the broadcast address |
| cfgPromisc | input | 1 | Accept every frame |
| cfgAllMcast | input | 1 | Treat every hash bin as set |
| hashWord0 | input | 32 | Hash bins 0..31 |
| hashWord1 | input | 32 | Hash bins 32..63 |
| staHi | input | 24 | Station address bytes 0..2, byte 0 at the top |
| staLo | input | 24 | Station address bytes 3..5, byte 3 at the top |
| decisionValid | output | 1 | Verdict strobe |
| accept | output | 1 | Verdict: 1 accept, 0 reject |

## Verification
The bound checker watches the verdict on every cycle:

- that it is a one-cycle pulse;
- that it always follows a consumed byte;
- that `accept` never rises outside that pulse;
- that promiscuous mode always accepts and that a fully disabled filter always rejects.

The exact station match, the CRC hash index and the split across the two table words can only be shown by the directed scenarios. So can the broadcast and all-multicast rules, the restart on a fresh start marker and the stalls between bytes. Those scenarios compare every verdict against a reference the bench computes on its own.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

  // Strobes from the byte sequencer to the datapath
  typedef struct packed {
    logic clearCrc;  // current byte is byte 0: restart CRC from preset
    logic takeByte;  // current byte belongs to the address
    logic finish;    // current byte is the last address byte
  } dpCtrl_t;

  // One byte of the MSB-shifting CRC, data bits entering LSB first
  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] crcIn,
                                               input logic [7:0] dataIn);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      fb = c[CRC_W-1] ^ dataIn[b];
      c = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/dafilt_ctrl.sv
module dafilt_ctrl
  import dafilt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    byteValid,
  input  logic    frameStart,
  output dpCtrl_t strobes
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

  // Index of the next expected byte; IDLE_CNT means no address in progress
  logic [CNT_W-1:0] byteIdx;

  always_comb begin
    strobes = '0;
    if (byteValid && frameStart) begin
      strobes.clearCrc = 1'b1;
      strobes.takeByte = 1'b1;
      strobes.finish   = (ADDR_BYTES == 1);
    end else if (byteValid && (byteIdx != IDLE_CNT)) begin
      strobes.takeByte = 1'b1;
      strobes.finish   = (byteIdx == LAST_IDX);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byteIdx <= IDLE_CNT;
    end else if (strobes.takeByte) begin
      byteIdx <= frameStart ? CNT_W'(1) : byteIdx + CNT_W'(1);
    end
  end

endmodule

// File: rtl/dafilt_decide.sv
module dafilt_decide #(
  parameter int unsigned ADDR_W    = 48,
  parameter int unsigned CRC_W     = 32,
  parameter int unsigned HASH_BITS = 6,
  parameter int unsigned TABLE_W   = 32,
  parameter int unsigned STA_W     = 24
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CRC_W-1:0]   crc,
  input  logic               cfgUcastEn,
  input  logic               cfgMcastEn,
  input  logic               cfgHashEn,
  input  logic               cfgBcastEn,
  input  logic               cfgPromisc,
  input  logic               cfgAllMcast,
  input  logic [TABLE_W-1:0] hashWord0,
  input  logic [TABLE_W-1:0] hashWord1,
  input  logic [STA_W-1:0]   staHi,
  input  logic [STA_W-1:0]   staLo,
  output logic               acceptNow
);
  localparam int unsigned BINS    = 1 << HASH_BITS;
  localparam int unsigned N_WORDS = BINS / TABLE_W;
  localparam int unsigned SEL_W   = $clog2(TABLE_W);

  logic [HASH_BITS-1:0] hashIdx;
  logic [BINS-1:0]      binVec;
  logic [TABLE_W-1:0]   words [N_WORDS];

  assign words[0] = hashWord0;
  assign words[N_WORDS-1] = hashWord1;

  // Lay the table words out as one vector, word 0 in the lowest bins
  for (genvar w = 0; w < N_WORDS; w++) begin : g_bins
    assign binVec[w*TABLE_W +: TABLE_W] = words[w] | {TABLE_W{cfgAllMcast}};
  end

  logic isMcast, isBcast, ucastHit, hashHit;

  assign hashIdx  = crc[CRC_W-1 -: HASH_BITS];
  assign hashHit  = binVec[{hashIdx[HASH_BITS-1 -: HASH_BITS-SEL_W], hashIdx[SEL_W-1:0]}];
  assign isMcast  = addr[ADDR_W-8];
  assign isBcast  = &addr;
  assign ucastHit = (addr == {staHi, staLo});

  always_comb begin
    acceptNow = 1'b0;
    if (cfgPromisc)
      acceptNow = 1'b1;
    else if (isBcast)
      acceptNow = cfgBcastEn;
    else if (isMcast)
      acceptNow = cfgMcastEn && cfgHashEn && hashHit;
    else
      acceptNow = cfgUcastEn && ucastHit;
  end

endmodule

// File: rtl/dafilt_datapath.sv
module dafilt_datapath
  import dafilt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  parameter int unsigned TABLE_W    = 32,
  parameter int unsigned STA_W      = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpCtrl_t            strobes,
  input  logic [7:0]         byteData,
  input  logic               cfgUcastEn,
  input  logic               cfgMcastEn,
  input  logic               cfgHashEn,
  input  logic               cfgBcastEn,
  input  logic               cfgPromisc,
  input  logic               cfgAllMcast,
  input  logic [TABLE_W-1:0] hashWord0,
  input  logic [TABLE_W-1:0] hashWord1,
  input  logic [STA_W-1:0]   staHi,
  input  logic [STA_W-1:0]   staLo,
  output logic               decisionValid,
  output logic               accept
);
  localparam int unsigned ADDR_W = ADDR_BYTES * 8;

  logic [ADDR_W-1:0] addrReg, addrNext;
  logic [CRC_W-1:0]  crcReg, crcNext, crcBase;
  logic              acceptNow;

  assign crcBase  = strobes.clearCrc ? '1 : crcReg;
  assign crcNext  = crcByte(crcBase, byteData);
  assign addrNext = {addrReg[ADDR_W-9:0], byteData};

  dafilt_decide #(
    .ADDR_W(ADDR_W), .CRC_W(CRC_W), .HASH_BITS(HASH_BITS),
    .TABLE_W(TABLE_W), .STA_W(STA_W)
  ) decide_i (
    .addr(addrNext), .crc(crcNext),
    .cfgUcastEn(cfgUcastEn), .cfgMcastEn(cfgMcastEn), .cfgHashEn(cfgHashEn),
    .cfgBcastEn(cfgBcastEn), .cfgPromisc(cfgPromisc), .cfgAllMcast(cfgAllMcast),
    .hashWord0(hashWord0), .hashWord1(hashWord1),
    .staHi(staHi), .staLo(staLo),
    .acceptNow(acceptNow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrReg       <= '0;
      crcReg        <= '1;
      decisionValid <= 1'b0;
      accept        <= 1'b0;
    end else begin
      if (strobes.takeByte) begin
        addrReg <= addrNext;
        crcReg  <= crcNext;
      end
      decisionValid <= strobes.finish;
      accept        <= strobes.finish && acceptNow;
    end
  end

endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
  import dafilt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  parameter int unsigned TABLE_W    = 32,
  parameter int unsigned STA_W      = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byteValid,
  input  logic               frameStart,
  input  logic [7:0]         byteData,
  input  logic               cfgUcastEn,
  input  logic               cfgMcastEn,
  input  logic               cfgHashEn,
  input  logic               cfgBcastEn,
  input  logic               cfgPromisc,
  input  logic               cfgAllMcast,
  input  logic [TABLE_W-1:0] hashWord0,
  input  logic [TABLE_W-1:0] hashWord1,
  input  logic [STA_W-1:0]   staHi,
  input  logic [STA_W-1:0]   staLo,
  output logic               decisionValid,
  output logic               accept
);
  dpCtrl_t strobes;

  dafilt_ctrl #(.ADDR_BYTES(ADDR_BYTES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid),
    .frameStart(frameStart), .strobes(strobes)
  );

  dafilt_datapath #(
    .ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS),
    .TABLE_W(TABLE_W), .STA_W(STA_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .byteData(byteData),
    .cfgUcastEn(cfgUcastEn), .cfgMcastEn(cfgMcastEn), .cfgHashEn(cfgHashEn),
    .cfgBcastEn(cfgBcastEn), .cfgPromisc(cfgPromisc), .cfgAllMcast(cfgAllMcast),
    .hashWord0(hashWord0), .hashWord1(hashWord1),
    .staHi(staHi), .staLo(staLo),
    .decisionValid(decisionValid), .accept(accept)
  );

endmodule

// File: rtl/dafilt_checker.sv
module dafilt_checker (
  input logic clk,
  input logic rst_n,
  input logic byteValid,
  input logic cfgUcastEn,
  input logic cfgMcastEn,
  input logic cfgBcastEn,
  input logic cfgPromisc,
  input logic decisionValid,
  input logic accept
);
  // Six bytes are needed per verdict, so two verdicts are never adjacent
  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    decisionValid |=> !decisionValid);

  assert_after_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
    decisionValid |-> $past(byteValid));

  assert_promisc_accepts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && $past(cfgPromisc)) |-> accept);

  assert_accept_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !decisionValid |-> !accept);

  assert_all_off_rejects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (decisionValid && !$past(cfgPromisc) && !$past(cfgUcastEn) &&
     !$past(cfgMcastEn) && !$past(cfgBcastEn)) |-> !accept);

endmodule

bind dafilt_top dafilt_checker chk_i (
  .clk(clk), .rst_n(rst_n), .byteValid(byteValid),
  .cfgUcastEn(cfgUcastEn), .cfgMcastEn(cfgMcastEn),
  .cfgBcastEn(cfgBcastEn), .cfgPromisc(cfgPromisc),
  .decisionValid(decisionValid), .accept(accept)
);

// File: tb/dafilt_top_tb_top.sv
`timescale 1ns/1ps
module dafilt_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byteValid = 1'b0, frameStart = 1'b0;
  logic [7:0] byteData = '0;
  logic cfgUcastEn = 0, cfgMcastEn = 0, cfgHashEn = 0, cfgBcastEn = 0, cfgPromisc = 0, cfgAllMcast = 0;
  logic [31:0] hashWord0 = '0, hashWord1 = '0;
  logic [23:0] staHi = 24'h0A1B2C, staLo = 24'h3D4E5F;
  logic decisionValid, accept;

  int checks = 0, failures = 0, cycles = 0;

  localparam logic [47:0] STATION = 48'h0A1B2C_3D4E5F;
  localparam logic [47:0] OTHER_U = 48'h0A1B2C_3D4E50;
  localparam logic [47:0] MCAST_A = 48'h01005E_0000FB;
  localparam logic [47:0] BCAST   = 48'hFFFFFF_FFFFFF;

  always #2 clk = ~clk;

  dafilt_top dut_i (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .frameStart(frameStart),
    .byteData(byteData), .cfgUcastEn(cfgUcastEn), .cfgMcastEn(cfgMcastEn),
    .cfgHashEn(cfgHashEn), .cfgBcastEn(cfgBcastEn), .cfgPromisc(cfgPromisc),
    .cfgAllMcast(cfgAllMcast), .hashWord0(hashWord0), .hashWord1(hashWord1),
    .staHi(staHi), .staLo(staLo), .decisionValid(decisionValid), .accept(accept)
  );

  // Bench-side hash index: preset ones, shift toward MSB, data LSB first, no inversion
  function automatic logic [5:0] refIndex(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d = a[47-8*i -: 8];
      for (int b = 0; b < 8; b++) begin
        logic top = r[31] ^ d[b];
        r = r << 1;
        if (top) r = r ^ 32'h04C11DB7;
      end
    end
    return r[31:26];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input logic u, m, h, b, p, al);
    @(negedge clk);
    {cfgUcastEn, cfgMcastEn, cfgHashEn, cfgBcastEn, cfgPromisc, cfgAllMcast} = {u, m, h, b, p, al};
  endtask

  // Send six bytes; optional idle cycle after each of the first five bytes
  task automatic sendAddr(input logic [47:0] a, input logic gaps, input logic expAcc, input string req);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = (i == 0); byteData = a[47-8*i -: 8];
      if (gaps && i < 5) begin
        @(negedge clk);
        byteValid = 1'b0; frameStart = 1'b0;
        check(!decisionValid, req, decisionValid, 0);
      end
    end
    @(negedge clk);
    byteValid = 1'b0; frameStart = 1'b0;
    check(decisionValid === 1'b1, {req, " valid"}, decisionValid, 1);
    check(accept === expAcc, {req, " verdict"}, accept, expAcc);
    @(negedge clk);
    check(!decisionValid && !accept, {req, " pulse end (R1)"}, decisionValid, 0);
  endtask

  task automatic testReset();
    check(!decisionValid && !accept, "R1 reset state", decisionValid, 0);
  endtask

  task automatic testUnicast();
    setCfg(1, 0, 0, 0, 0, 0);
    sendAddr(STATION, 0, 1, "R4 station match");
    sendAddr(OTHER_U, 0, 0, "R4 last byte differs");
    setCfg(0, 1, 1, 1, 0, 0);
    sendAddr(STATION, 0, 0, "R10 unicast disabled");
  endtask

  task automatic testHash();
    logic [5:0] idx = refIndex(MCAST_A);
    logic [63:0] tbl = 64'd1 << idx;
    setCfg(0, 1, 1, 0, 0, 0);
    {hashWord1, hashWord0} = tbl;
    sendAddr(MCAST_A, 0, 1, "R5 R6 hash hit");
    {hashWord1, hashWord0} = ~tbl;
    sendAddr(MCAST_A, 0, 0, "R6 hash miss");
    {hashWord1, hashWord0} = tbl;
    setCfg(0, 1, 0, 0, 0, 0);
    sendAddr(MCAST_A, 0, 0, "R6 hash disabled");
    setCfg(0, 0, 1, 0, 0, 0);
    sendAddr(MCAST_A, 0, 0, "R6 mcast disabled");
    // Swap the words: the selected bin now lands in the other word
    {hashWord0, hashWord1} = tbl;
    setCfg(0, 1, 1, 0, 0, 0);
    sendAddr(MCAST_A, 0, 0, "R6 word select");
    {hashWord1, hashWord0} = '0;
    setCfg(0, 1, 1, 0, 0, 1);
    sendAddr(MCAST_A, 0, 1, "R7 all-multicast");
    setCfg(0, 0, 1, 0, 0, 1);
    sendAddr(MCAST_A, 0, 0, "R7 all-multicast needs mcast enable");
  endtask

  task automatic testBcastPromisc();
    {hashWord1, hashWord0} = '1;
    setCfg(1, 1, 1, 0, 0, 1);
    sendAddr(BCAST, 0, 0, "R8 broadcast disabled");
    setCfg(0, 0, 0, 1, 0, 0);
    sendAddr(BCAST, 0, 1, "R8 broadcast enabled");
    setCfg(0, 0, 0, 0, 1, 0);
    sendAddr(OTHER_U, 0, 1, "R3 promiscuous unicast");
    sendAddr(MCAST_A, 1, 1, "R3 promiscuous multicast");
    {hashWord1, hashWord0} = '0;
  endtask

  task automatic testFraming();
    int seen = 0;
    setCfg(1, 0, 0, 0, 0, 0);
    // Bytes without a start marker while idle are ignored (R2)
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = 1'b0; byteData = 8'h0A;
      seen += decisionValid;
    end
    @(negedge clk); byteValid = 1'b0;
    seen += decisionValid;
    @(negedge clk); seen += decisionValid;
    check(seen == 0, "R2 bytes without start ignored", seen, 0);
    // Partial address abandoned by a new start marker
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = (i == 0); byteData = 8'hEE;
    end
    sendAddr(STATION, 0, 1, "R2 restart on start marker");
    // Extra bytes after the sixth produce no verdict
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      byteValid = 1'b1; frameStart = 1'b0; byteData = 8'h5F;
      seen += decisionValid;
    end
    @(negedge clk); byteValid = 1'b0;
    seen += decisionValid;
    @(negedge clk); seen += decisionValid;
    check(seen == 0, "R2 trailing bytes ignored", seen, 0);
    sendAddr(STATION, 1, 1, "R9 gaps between bytes");
    sendAddr(OTHER_U, 1, 0, "R9 gaps reject");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testUnicast();
    testHash();
    testBcastPromisc();
    testFraming();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule